// File: doc/BRIEF.md
# Flow Port Selector

This block decides which of four outgoing network ports carries a flow or a packet. A request arrives as a strobe with a 96-bit flow key (two 32-bit addresses and two 16-bit port numbers) and an operation code. The operation code marks the request as a plain packet, a connection opening, or a connection closing. The block answers one clock later with either a chosen port index and a valid pulse, or a pulse meaning that no port can take the traffic.

Five distribution policies are available through a mode input. Rotating, weighted rotating, fewest-connections, key-hash and primary/backup selection each read the same per-port link-up vector, so a port whose link is down is never picked. The block keeps an active-connection counter per port. An opening adds one to the counter of the port that was chosen. A closing removes one from the port that the requester names.

Top module: `flow_port_selector`

## Requirements
- R1: Every request with `req_op` other than 2'b10 (00 and 11 = packet, 01 = open) is answered on the next cycle with exactly one of `sel_valid` or `no_port` high for one cycle. A close request (2'b10) and an idle cycle leave both low.
- R2: A port whose `link_up` bit is 0 is never selected in any mode. If no port has its link up, the answer is `no_port` and `sel_valid` stays low.
- R3: In rotating mode (`mode_sel` 0, and the unused codes 5 to 7), each request takes the first up port above the previously chosen one, wrapping from 3 to 0. After reset the search starts at port 0.
- R4: In weighted mode (`mode_sel` 1), port p has a 4-bit weight in `port_weight[4p+3:4p]`, and only up ports with a nonzero weight are eligible. The block holds a current port (0 after reset) and a used count (0). A request goes to the first eligible port at or above the current port, wrapping. The used count continues if that port is the current one and otherwise restarts, and then adds one. When the count reaches the port's weight, the current port moves to the next index and the count clears. If no port is eligible, the answer is `no_port`.
- R5: In fewest-connections mode (`mode_sel` 2), the request goes to the up port with the smallest connection count. A tie goes to the lowest index.
- R6: In hash mode (`mode_sel` 3), the start port is the XOR of all 48 two-bit slices of {src_addr, dst_addr, src_l4, dst_l4}, so one key always gives the same port while the links do not change. If the start port is down, the next higher-index up port is used, wrapping.
- R7: In primary/backup mode (`mode_sel` 4), traffic goes to `primary_port` while it is qualified. Otherwise it goes to the lowest-index up port other than the primary. If no such port exists, it goes to the primary when its link is up.
- R8: The primary is qualified only when its link is up and has been up, without a change of `primary_port`, for at least `revert_hold` clock edges before the request edge. A drop of its link restarts this count.
- R9: Each port has an 8-bit connection count, shown in `conn_count[8p+7:8p]`. It rises by one when an open request is given that port, saturating at 255. It falls by one on a close request that names that port in `close_port`, and it stays at 0 when it is already 0.
- R10: When `mode_sel` differs from the mode of the previous non-close request, the request uses the reset pointers: rotating search starts at port 0, and the weighted current port is 0 with the count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00/11 packet, 01 open, 10 close |
| src_addr | input | 32 | Source address of the flow key |
| dst_addr | input | 32 | Destination address of the flow key |
| src_l4 | input | 16 | Source transport port of the flow key |
| dst_l4 | input | 16 | Destination transport port of the flow key |
| close_port | input | 2 | Port whose count a close request lowers |
| link_up | input | 4 | Per-port link status, 1 = up |
| port_weight | input | 16 | Four 4-bit weights for weighted mode |
| mode_sel | input | 3 | Distribution policy |
| primary_port | input | 2 | Primary port for primary/backup mode |
| revert_hold | input | 8 | Up-time needed before the primary takes traffic back |
| sel_valid | output | 1 | One-cycle pulse: `sel_port` is valid |
| sel_port | output | 2 | Chosen port |
| no_port | output | 1 | One-cycle pulse: no port could be chosen |
| conn_count | output | 32 | Four 8-bit active-connection counts |

## Verification
A stale rotating or weighted pointer shows up on the very next request in that mode, as a port one step off the expected sequence. A counter that wraps below zero or misses an increment changes `conn_count` in the cycle after the faulty request. It also changes the fewest-connections choice on every later open. A wrong primary up-time count moves the failback by one or more requests, so the bench requests on every cycle around the end of the hold window. A mode-change slip only shows on the first request after the switch, so mode switches are mixed densely into the random traffic.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam logic [2:0] MODE_RR    = 3'd0;
  localparam logic [2:0] MODE_WRR   = 3'd1;
  localparam logic [2:0] MODE_LEAST = 3'd2;
  localparam logic [2:0] MODE_HASH  = 3'd3;
  localparam logic [2:0] MODE_STBY  = 3'd4;

  localparam logic [1:0] OP_PKT   = 2'b00;
  localparam logic [1:0] OP_OPEN  = 2'b01;
  localparam logic [1:0] OP_CLOSE = 2'b10;

  localparam int KEY_W = 96;
endpackage

// File: rtl/fps_rotate_pick.sv
// First eligible index at or above a start index, wrapping around.
module fps_rotate_pick #(
  parameter int NP = 4,
  parameter int PW = $clog2(NP)
) (
  input  logic [NP-1:0] elig,
  input  logic [PW-1:0] start,
  output logic          found,
  output logic [PW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    // descending offsets: the smallest offset is written last and wins
    for (int i = NP - 1; i >= 0; i--) begin
      if (elig[(int'(start) + i) % NP]) begin
        found = 1'b1;
        idx   = PW'((int'(start) + i) % NP);
      end
    end
  end
endmodule

// File: rtl/fps_conn_table.sv
// Per-port active-connection counters with a fewest-count finder.
module fps_conn_table #(
  parameter int NP    = 4,
  parameter int PW    = $clog2(NP),
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_en,
  input  logic [PW-1:0]      inc_idx,
  input  logic               dec_en,
  input  logic [PW-1:0]      dec_idx,
  input  logic [NP-1:0]      elig,
  output logic [NP*CNT_W-1:0] cnt_flat,
  output logic               min_found,
  output logic [PW-1:0]      min_idx
);
  logic [CNT_W-1:0] cnt_q [NP];
  logic [CNT_W-1:0] cnt_d [NP];
  logic [CNT_W-1:0] best;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cnt_d[p] = cnt_q[p];
      if (inc_en && (int'(inc_idx) == p) && (cnt_q[p] != {CNT_W{1'b1}}))
        cnt_d[p] = cnt_q[p] + 1'b1;
      if (dec_en && (int'(dec_idx) == p) && (cnt_q[p] != '0))
        cnt_d[p] = cnt_q[p] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) cnt_q[p] <= '0;
    end else begin
      for (int p = 0; p < NP; p++) cnt_q[p] <= cnt_d[p];
    end
  end

  always_comb begin
    min_found = 1'b0;
    min_idx   = '0;
    best      = '1;
    for (int p = 0; p < NP; p++) begin
      if (elig[p] && (!min_found || (cnt_q[p] < best))) begin
        min_found = 1'b1;
        min_idx   = PW'(p);
        best      = cnt_q[p];
      end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_flat
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
  end
endmodule

// File: rtl/fps_standby.sv
// Primary/backup choice with a link up-time qualifier for failback.
module fps_standby #(
  parameter int NP     = 4,
  parameter int PW     = $clog2(NP),
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     link_up,
  input  logic [PW-1:0]     primary,
  input  logic [HOLD_W-1:0] hold,
  output logic              found,
  output logic [PW-1:0]     idx
);
  logic [PW-1:0]     pri_q;
  logic [HOLD_W-1:0] run_q, run_d;
  logic              pri_up, pri_ok, bk_found;
  logic [PW-1:0]     bk_idx;

  assign pri_up = link_up[primary];
  assign pri_ok = pri_up && (run_q >= hold);

  always_comb begin
    if ((primary != pri_q) || !pri_up) run_d = '0;
    else if (run_q == {HOLD_W{1'b1}})  run_d = run_q;
    else                               run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      run_q <= '0;
    end else begin
      pri_q <= primary;
      run_q <= run_d;
    end
  end

  always_comb begin
    bk_found = 1'b0;
    bk_idx   = '0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (link_up[p] && (int'(primary) != p)) begin
        bk_found = 1'b1;
        bk_idx   = PW'(p);
      end
    end
  end

  always_comb begin
    if (pri_ok)        begin found = 1'b1; idx = primary; end
    else if (bk_found) begin found = 1'b1; idx = bk_idx;  end
    else               begin found = pri_up; idx = primary; end
  end
endmodule

// File: rtl/flow_port_selector.sv
module flow_port_selector #(
  parameter int NP     = 4,
  parameter int CNT_W  = 8,
  parameter int WT_W   = 4,
  parameter int HOLD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [31:0]         src_addr,
  input  logic [31:0]         dst_addr,
  input  logic [15:0]         src_l4,
  input  logic [15:0]         dst_l4,
  input  logic [1:0]          close_port,
  input  logic [3:0]          link_up,
  input  logic [15:0]         port_weight,
  input  logic [2:0]          mode_sel,
  input  logic [1:0]          primary_port,
  input  logic [HOLD_W-1:0]   revert_hold,
  output logic                sel_valid,
  output logic [1:0]          sel_port,
  output logic                no_port,
  output logic [NP*CNT_W-1:0] conn_count
);
  import fps_pkg::*;

  localparam int PW = $clog2(NP);
  localparam logic [PW-1:0] LAST = PW'(NP - 1);
  localparam int NPICK = 3;  // rotating, weighted, hash

  logic [KEY_W-1:0] key;
  logic [PW-1:0]    hash_start;
  logic [WT_W-1:0]  wt [NP];
  logic [NP-1:0]    wrr_elig;

  logic [2:0]       mode_seen_q, mode_seen_d;
  logic [PW-1:0]    rr_last_q, rr_last_d;
  logic [PW-1:0]    wrr_ptr_q, wrr_ptr_d;
  logic [WT_W-1:0]  wrr_cnt_q, wrr_cnt_d;
  logic             out_v_q, out_v_d, out_n_q, out_n_d;
  logic [PW-1:0]    out_p_q, out_p_d;

  logic             sel_req, mode_chg, mode_is_rr;
  logic [PW-1:0]    rr_base, rr_start, wrr_ptr_eff;
  logic [WT_W-1:0]  wrr_cnt_eff;
  logic [WT_W:0]    wrr_used;
  logic             pick_found;
  logic [PW-1:0]    pick_idx;

  logic [NP-1:0]    pk_elig  [NPICK];
  logic [PW-1:0]    pk_start [NPICK];
  logic             pk_found [NPICK];
  logic [PW-1:0]    pk_idx   [NPICK];

  logic             lc_found, sb_found;
  logic [PW-1:0]    lc_idx, sb_idx;

  function automatic logic [PW-1:0] fold_key(input logic [KEY_W-1:0] k);
    logic [PW-1:0] h;
    h = '0;
    for (int i = 0; i < KEY_W / PW; i++) h = h ^ k[i*PW +: PW];
    return h;
  endfunction

  assign key        = {src_addr, dst_addr, src_l4, dst_l4};
  assign hash_start = fold_key(key);

  for (genvar g = 0; g < NP; g++) begin : g_wt
    assign wt[g]       = port_weight[g*WT_W +: WT_W];
    assign wrr_elig[g] = link_up[g] && (port_weight[g*WT_W +: WT_W] != '0);
  end

  assign sel_req     = req_valid && (req_op != OP_CLOSE);
  assign mode_chg    = (mode_sel != mode_seen_q);
  assign mode_is_rr  = (mode_sel == MODE_RR) || (mode_sel > MODE_STBY);
  assign rr_base     = mode_chg ? LAST : rr_last_q;
  assign rr_start    = (rr_base == LAST) ? '0 : rr_base + 1'b1;
  assign wrr_ptr_eff = mode_chg ? '0 : wrr_ptr_q;
  assign wrr_cnt_eff = mode_chg ? '0 : wrr_cnt_q;

  assign pk_elig[0]  = link_up;
  assign pk_start[0] = rr_start;
  assign pk_elig[1]  = wrr_elig;
  assign pk_start[1] = wrr_ptr_eff;
  assign pk_elig[2]  = link_up;
  assign pk_start[2] = hash_start;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    fps_rotate_pick #(.NP(NP), .PW(PW)) u_pick (
      .elig  (pk_elig[g]),
      .start (pk_start[g]),
      .found (pk_found[g]),
      .idx   (pk_idx[g])
    );
  end

  fps_conn_table #(.NP(NP), .PW(PW), .CNT_W(CNT_W)) u_conn (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_en    (sel_req && (req_op == OP_OPEN) && pick_found),
    .inc_idx   (pick_idx),
    .dec_en    (req_valid && (req_op == OP_CLOSE)),
    .dec_idx   (close_port),
    .elig      (link_up),
    .cnt_flat  (conn_count),
    .min_found (lc_found),
    .min_idx   (lc_idx)
  );

  fps_standby #(.NP(NP), .PW(PW), .HOLD_W(HOLD_W)) u_stby (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .primary (primary_port),
    .hold    (revert_hold),
    .found   (sb_found),
    .idx     (sb_idx)
  );

  always_comb begin
    case (mode_sel)
      MODE_WRR:   begin pick_found = pk_found[1]; pick_idx = pk_idx[1]; end
      MODE_LEAST: begin pick_found = lc_found;    pick_idx = lc_idx;    end
      MODE_HASH:  begin pick_found = pk_found[2]; pick_idx = pk_idx[2]; end
      MODE_STBY:  begin pick_found = sb_found;    pick_idx = sb_idx;    end
      default:    begin pick_found = pk_found[0]; pick_idx = pk_idx[0]; end
    endcase
  end

  assign wrr_used = {1'b0, (pick_idx == wrr_ptr_eff) ? wrr_cnt_eff : {WT_W{1'b0}}} + 1'b1;

  always_comb begin
    mode_seen_d = mode_seen_q;
    rr_last_d   = rr_last_q;
    wrr_ptr_d   = wrr_ptr_q;
    wrr_cnt_d   = wrr_cnt_q;
    if (sel_req) begin
      mode_seen_d = mode_sel;
      if (mode_is_rr) rr_last_d = pick_found ? pick_idx : rr_base;
      if (mode_sel == MODE_WRR) begin
        wrr_ptr_d = wrr_ptr_eff;
        wrr_cnt_d = wrr_cnt_eff;
        if (pick_found) begin
          if (wrr_used >= {1'b0, wt[pick_idx]}) begin
            wrr_ptr_d = (pick_idx == LAST) ? '0 : pick_idx + 1'b1;
            wrr_cnt_d = '0;
          end else begin
            wrr_ptr_d = pick_idx;
            wrr_cnt_d = wrr_used[WT_W-1:0];
          end
        end
      end
    end
    out_v_d = sel_req && pick_found;
    out_n_d = sel_req && !pick_found;
    out_p_d = pick_found ? pick_idx : out_p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_seen_q <= MODE_RR;
      rr_last_q   <= LAST;
      wrr_ptr_q   <= '0;
      wrr_cnt_q   <= '0;
      out_v_q     <= 1'b0;
      out_n_q     <= 1'b0;
      out_p_q     <= '0;
    end else begin
      mode_seen_q <= mode_seen_d;
      rr_last_q   <= rr_last_d;
      wrr_ptr_q   <= wrr_ptr_d;
      wrr_cnt_q   <= wrr_cnt_d;
      out_v_q     <= out_v_d;
      out_n_q     <= out_n_d;
      out_p_q     <= out_p_d;
    end
  end

  assign sel_valid = out_v_q;
  assign no_port   = out_n_q;
  assign sel_port  = out_p_q;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int NP    = 4,
  parameter int CNT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic [1:0]          close_port,
  input logic [3:0]          link_up,
  input logic [2:0]          mode_sel,
  input logic                sel_valid,
  input logic [1:0]          sel_port,
  input logic                no_port,
  input logic [NP*CNT_W-1:0] conn_count
);
  logic             is_sel, is_close, close_at_zero;
  logic [CNT_W-1:0] close_cnt;

  assign is_sel        = req_valid && (req_op != 2'b10);
  assign is_close      = req_valid && (req_op == 2'b10);
  assign close_cnt     = conn_count[close_port*CNT_W +: CNT_W];
  assign close_at_zero = is_close && (close_cnt == '0);

  function automatic logic fewest_ok(input logic [NP*CNT_W-1:0] c,
                                     input logic [3:0] up, input logic [1:0] s);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < NP; p++)
      if (up[p] && (c[p*CNT_W +: CNT_W] < c[s*CNT_W +: CNT_W])) ok = 1'b0;
    return ok;
  endfunction

  assert_one_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_valid && no_port));
  assert_answer_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_sel |=> (sel_valid || no_port));
  assert_close_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_close || !req_valid) |=> (!sel_valid && !no_port));
  assert_port_was_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_sel |=> (!sel_valid || ((($past(link_up) >> sel_port) & 4'd1) != 4'd0)));
  assert_all_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sel && (link_up == 4'd0)) |=> no_port);
  assert_fewest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sel && (mode_sel == 3'd2)) |=> (!sel_valid ||
      fewest_ok($past(conn_count), $past(link_up), sel_port)));
  assert_floor_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    close_at_zero |=> $stable(conn_count));
endmodule

bind flow_port_selector fps_checker #(.NP(NP), .CNT_W(CNT_W)) u_fps_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .close_port (close_port),
  .link_up    (link_up),
  .mode_sel   (mode_sel),
  .sel_valid  (sel_valid),
  .sel_port   (sel_port),
  .no_port    (no_port),
  .conn_count (conn_count)
);

// File: tb/tb_flow_port_selector.sv
`timescale 1ns/1ps
module tb_flow_port_selector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] src_l4, dst_l4;
  logic [1:0]  close_port;
  logic [3:0]  link_up;
  logic [15:0] port_weight;
  logic [2:0]  mode_sel;
  logic [1:0]  primary_port;
  logic [7:0]  revert_hold;
  logic        sel_valid, no_port;
  logic [1:0]  sel_port;
  logic [31:0] conn_count;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  int m_seen, m_rr_last, m_wrr_ptr, m_wrr_cnt, m_run, m_pri_prev;
  int m_cnt [4];

  always #10 clk = ~clk;

  flow_port_selector dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_l4(src_l4), .dst_l4(dst_l4),
    .close_port(close_port), .link_up(link_up), .port_weight(port_weight),
    .mode_sel(mode_sel), .primary_port(primary_port), .revert_hold(revert_hold),
    .sel_valid(sel_valid), .sel_port(sel_port), .no_port(no_port),
    .conn_count(conn_count)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int first_from(input logic [3:0] elig, input int start);
    for (int i = 0; i < 4; i++) if (elig[(start + i) % 4]) return (start + i) % 4;
    return -1;
  endfunction

  function automatic int fold(input logic [95:0] k);
    logic [1:0] h = 2'b00;
    for (int i = 0; i < 48; i++) h ^= k[2*i +: 2];
    return int'(h);
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R3";
    endcase
  endfunction

  // One clock cycle: inputs are applied now (at a falling edge), outputs
  // are checked at the next falling edge.
  task automatic cyc(input bit rv, input logic [1:0] op, input logic [95:0] key,
                     input logic [1:0] cp, input string tag_ovr);
    bit exp_v = 0, exp_n = 0;
    int exp_p = 0, p = -1, md, wp, wc, rrb, used;
    logic [3:0] we;
    string tag;
    md = int'(mode_sel);
    tag = (tag_ovr != "") ? tag_ovr : mode_tag(md);
    req_valid = rv; req_op = op; close_port = cp;
    {src_addr, dst_addr, src_l4, dst_l4} = key;
    if (rv && op != 2'b10) begin
      bit chg = (md != m_seen);
      rrb = chg ? 3 : m_rr_last;
      wp  = chg ? 0 : m_wrr_ptr;
      wc  = chg ? 0 : m_wrr_cnt;
      case (md)
        1: begin
          for (int i = 0; i < 4; i++) we[i] = link_up[i] && (port_weight[4*i +: 4] != 0);
          p = first_from(we, wp);
          m_wrr_ptr = wp; m_wrr_cnt = wc;
          if (p >= 0) begin
            used = ((p == wp) ? wc : 0) + 1;
            if (used >= int'(port_weight[4*p +: 4])) begin
              m_wrr_ptr = (p + 1) % 4; m_wrr_cnt = 0;
            end else begin
              m_wrr_ptr = p; m_wrr_cnt = used;
            end
          end
        end
        2: for (int i = 0; i < 4; i++)
             if (link_up[i] && (p < 0 || m_cnt[i] < m_cnt[p])) p = i;
        3: p = first_from(link_up, fold(key));
        4: begin
          int pr = int'(primary_port);
          if (link_up[pr] && m_run >= int'(revert_hold)) p = pr;
          else begin
            for (int i = 3; i >= 0; i--) if (link_up[i] && i != pr) p = i;
            if (p < 0 && link_up[pr]) p = pr;
          end
        end
        default: begin
          p = first_from(link_up, (rrb + 1) % 4);
          m_rr_last = (p >= 0) ? p : rrb;
        end
      endcase
      m_seen = md;
      if (p >= 0) begin
        exp_v = 1; exp_p = p;
        if (op == 2'b01 && m_cnt[p] < 255) m_cnt[p]++;
      end else exp_n = 1;
    end else if (rv) begin
      if (m_cnt[cp] > 0) m_cnt[cp]--;
    end
    @(posedge clk);
    if (primary_port != m_pri_prev[1:0] || !link_up[primary_port]) m_run = 0;
    else if (m_run < 255) m_run++;
    m_pri_prev = int'(primary_port);
    @(negedge clk);
    req_valid = 0;
    if (rv && op != 2'b10) begin
      chk(exp_n ? "R2" : tag, "valid", int'(sel_valid), int'(exp_v));
      chk("R2", "no_port", int'(no_port), int'(exp_n));
      if (exp_v) chk(tag, "port", int'(sel_port), exp_p);
    end else begin
      chk("R1", "valid quiet", int'(sel_valid), 0);
      chk("R1", "no_port quiet", int'(no_port), 0);
    end
    for (int i = 0; i < 4; i++)
      chk("R9", "count", int'(conn_count[8*i +: 8]), m_cnt[i]);
  endtask

  function automatic logic [95:0] rnd_key();
    return {$urandom % 8, 32'h0a000001, 16'(1000 + $urandom % 4), 16'd80};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_op = 0; close_port = 0;
    {src_addr, dst_addr, src_l4, dst_l4} = '0;
    link_up = 4'hF; port_weight = 16'h1111; mode_sel = 0;
    primary_port = 0; revert_hold = 0;
    m_seen = 0; m_rr_last = 3; m_wrr_ptr = 0; m_wrr_cnt = 0; m_run = 0; m_pri_prev = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1 R9: reset state
    chk("R1", "reset valid", int'(sel_valid), 0);
    chk("R1", "reset no_port", int'(no_port), 0);
    chk("R9", "reset counts", int'(conn_count), 0);
    rst_n = 1;

    // R3: rotation with a hole
    link_up = 4'b1011;
    for (int i = 0; i < 5; i++) cyc(1, 2'b00, rnd_key(), 0, "R3");
    // R2: no link up
    link_up = 4'b0000;
    cyc(1, 2'b01, rnd_key(), 0, "R2");
    link_up = 4'hF;
    // R10: mode change back and forth resets the rotation
    mode_sel = 3'd2; cyc(1, 2'b00, rnd_key(), 0, "R10");
    mode_sel = 3'd0; cyc(1, 2'b00, rnd_key(), 0, "R10");
    // R4: weights 2,1,0,3
    mode_sel = 3'd1; port_weight = 16'h3012;
    for (int i = 0; i < 9; i++) cyc(1, 2'b00, rnd_key(), 0, "R4");
    // R5 with R9: opens and closes, including close at zero
    mode_sel = 3'd2;
    for (int i = 0; i < 6; i++) cyc(1, 2'b01, rnd_key(), 0, "R5");
    cyc(1, 2'b10, rnd_key(), 2'd1, "R9");
    cyc(1, 2'b10, rnd_key(), 2'd1, "R9");
    cyc(1, 2'b10, rnd_key(), 2'd1, "R9");
    cyc(1, 2'b01, rnd_key(), 0, "R5");
    // R6: start port 3 is down, wraps to port 0
    mode_sel = 3'd3; link_up = 4'b0111;
    cyc(1, 2'b00, 96'h3, 0, "R6");
    cyc(1, 2'b00, 96'h3, 0, "R6");
    link_up = 4'hF;
    // R7 R8: failover and delayed return to the primary
    mode_sel = 3'd4; primary_port = 2; revert_hold = 8'd5;
    for (int i = 0; i < 8; i++) cyc(0, 2'b00, '0, 0, "R8");
    cyc(1, 2'b00, rnd_key(), 0, "R7");
    link_up = 4'b1011;
    cyc(1, 2'b00, rnd_key(), 0, "R7");
    link_up = 4'hF;
    for (int i = 0; i < 9; i++) cyc(1, 2'b00, rnd_key(), 0, "R8");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 8 == 0) mode_sel = 3'($urandom % 8);
      if ($urandom % 6 == 0) link_up = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      if ($urandom % 20 == 0) port_weight = 16'($urandom) & 16'h3333;
      if ($urandom % 50 == 0) primary_port = 2'($urandom);
      if ($urandom % 50 == 0) revert_hold = 8'($urandom % 12);
      cyc(($urandom % 4) != 0, 2'($urandom), rnd_key(), 2'($urandom), "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule